// File: doc/BRIEF.md
# Power Management Event Controller

This block gathers four power management event sources into a pair of 16-bit registers: a status word whose bits latch on hardware events, and an enable word that decides which latched events reach the interrupt outputs. The sources are a free-running overflow timer, a firmware release request, a power button and a real-time-clock alarm. Software reads both words through a small register port. It clears a status bit by writing a 1 to that bit. A wake request comes out alongside the two interrupt lines.

An input mode pin sends enabled timer, power button and RTC events either to the system control interrupt line (SCI) or to the system management interrupt line (SMI). Enabled firmware-release events always go to SCI. The RTC enable bit sits in a separate reset domain, so an armed RTC alarm still works after an ordinary reset. All interface pins are plain control and status signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pm_event_ctrl`

## Requirements
- R1: After both resets, the status word (address 2'b00) and the enable word (address 2'b10) read 0000h, and `sci_irq`, `smi_irq` and `wake` are 0.
- R2: Timer status (bit 0) sets on every rising edge of bit `TMR_TAP` of a `TMR_W`-bit counter that is cleared by `rst_n` and counts every clock. The first set is visible after clock edge 2^TMR_TAP + 1 following reset release. Later sets follow every 2^(TMR_TAP+1) cycles.
- R3: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R4: If a hardware set and a write-1 clear of the same status bit fall in the same cycle, the bit ends up 1.
- R5: Timer routing follows timer enable (enable bit 0) and `sci_mode`. Enable 0 gives neither interrupt. Enable 1 with mode 0 gives SMI. Enable 1 with mode 1 gives SCI. With the enable word at zero, both interrupts stay low, and `smi_irq` is never high while `sci_mode` is 1.
- R6: `fw_release` sets global status (bit 5). SCI is raised when status bit 5 and enable bit 5 are both 1. This event never raises SMI.
- R7: `pwrbtn_event` sets power button status (bit 8) whatever enable bit 8 holds. Enable bit 8 routes the event to SCI or SMI according to `sci_mode`.
- R8: `wake` is 1 whenever power button status is 1, independent of its enable.
- R9: `rtc_event` sets RTC status (bit 10). If enable bit 10 is 1, this raises SCI or SMI (chosen by `sci_mode`) and `wake`. If enable bit 10 is 0, it raises none of these.
- R10: Enable bit 10 keeps its value through `rst_n`. Only `rtc_rst_n` clears it. All other bits of both words clear on `rst_n`.
- R11: Only bits 0, 5, 8 and 10 are implemented in either word. Reserved bits, and reads of the unused addresses, return 0 and ignore writes. A read returns the register value held before the edge that captured `reg_rd`, and the value appears after that edge.
- R12: `sci_irq` and `smi_irq` are level outputs. They drop in the cycle after software clears the last enabled, set status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main reset, asynchronous, active low |
| rtc_rst_n | input | 1 | RTC-domain reset, asynchronous, active low |
| sci_mode | input | 1 | 1 routes enabled events to SCI, 0 routes them to SMI |
| fw_release | input | 1 | Firmware release request, high for each cycle it is requested |
| rtc_event | input | 1 | RTC alarm event |
| pwrbtn_event | input | 1 | Power button press |
| reg_addr | input | 2 | Register select: 2'b00 status, 2'b10 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| sci_irq | output | 1 | System control interrupt level |
| smi_irq | output | 1 | System management interrupt level, active high |
| wake | output | 1 | Wake request level |

## Verification
An event input or a write that is high at a clock edge changes the status word at that same edge. The interrupt and wake outputs are combinational from the registers, so they follow on the same cycle and the bench samples them at the next falling edge. A read value appears one edge after the strobe is captured, and it shows the state from before that edge. The bench accounts for this extra edge at every read. For the timer, the bench counts rising edges from reset release with a small counter configuration. It then brackets the first set and the next set between a read that must return 0 and a read one edge later that must return 1.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned NSRC  = 4;

  // source indices inside the compact per-source vectors
  localparam int unsigned SRC_TMR = 0;
  localparam int unsigned SRC_GBL = 1;
  localparam int unsigned SRC_PWR = 2;
  localparam int unsigned SRC_RTC = 3;

  // bit position of each source in the software-visible words
  localparam int unsigned SRC_POS [NSRC] = '{0, 5, 8, 10};

  localparam logic [REG_W-1:0] BIT_MASK = 16'h0521;

  localparam logic [1:0] ADDR_STS = 2'b00;
  localparam logic [1:0] ADDR_EN  = 2'b10;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/pm_ovf_timer.sv
module pm_ovf_timer #(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned TMR_TAP = 22
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [TMR_W-1:0] STEP = 1;

  logic [TMR_W-1:0] cnt_q;
  logic             tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + STEP;
      tap_q <= cnt_q[TMR_TAP];
    end
  end

  // high for the one cycle in which the tap bit has just gone high
  assign tick = cnt_q[TMR_TAP] & ~tap_q;
endmodule

// File: rtl/pm_status_bank.sv
module pm_status_bank
  import pm_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_v,
  input  src_vec_t clr_v,
  output src_vec_t sts
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_v[i]) q <= 1'b1;   // a set beats a clear in the same cycle
      else if (clr_v[i]) q <= 1'b0;
    end
    assign sts[i] = q;
  end
endmodule

// File: rtl/pm_enable_bank.sv
module pm_enable_bank
  import pm_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rtc_rst_n,
  input  logic     we,
  input  src_vec_t wbits,
  output src_vec_t en
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic q;
    if (i == SRC_RTC) begin : g_rtc_dom
      always_ff @(posedge clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) q <= 1'b0;
        else if (we)    q <= wbits[i];
      end
    end else begin : g_core_dom
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= wbits[i];
      end
    end
    assign en[i] = q;
  end
endmodule

// File: rtl/pm_event_route.sv
module pm_event_route
  import pm_evt_pkg::*;
(
  input  src_vec_t sts,
  input  src_vec_t en,
  input  logic     sci_mode,
  output logic     sci,
  output logic     smi,
  output logic     wake
);
  src_vec_t hit;
  logic     steerable;

  assign hit       = sts & en;
  assign steerable = hit[SRC_TMR] | hit[SRC_PWR] | hit[SRC_RTC];

  assign sci  = hit[SRC_GBL] | (sci_mode & steerable);
  assign smi  = ~sci_mode & steerable;
  assign wake = sts[SRC_PWR] | hit[SRC_RTC];
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W   = 24,
  parameter int unsigned TMR_TAP = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rtc_rst_n,
  input  logic        sci_mode,
  input  logic        fw_release,
  input  logic        rtc_event,
  input  logic        pwrbtn_event,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sci_irq,
  output logic        smi_irq,
  output logic        wake
);
  logic     tmr_tick;
  src_vec_t set_v, clr_v, wsel, sts_v, en_v;
  word_t    sts_word, en_word;
  logic     rsvd_unused;

  assign rsvd_unused = ^(reg_wdata & ~BIT_MASK);

  pm_ovf_timer #(.TMR_W(TMR_W), .TMR_TAP(TMR_TAP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick)
  );

  always_comb begin
    sts_word = '0;
    en_word  = '0;
    for (int i = 0; i < NSRC; i++) begin
      wsel[i]              = reg_wdata[SRC_POS[i]];
      sts_word[SRC_POS[i]] = sts_v[i];
      en_word[SRC_POS[i]]  = en_v[i];
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[SRC_TMR] = tmr_tick;
    set_v[SRC_GBL] = fw_release;
    set_v[SRC_PWR] = pwrbtn_event;
    set_v[SRC_RTC] = rtc_event;
    clr_v          = (reg_wr && reg_addr == ADDR_STS) ? wsel : '0;
  end

  pm_status_bank u_sts (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .sts(sts_v)
  );

  pm_enable_bank u_en (
    .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n),
    .we(reg_wr && reg_addr == ADDR_EN), .wbits(wsel), .en(en_v)
  );

  pm_event_route u_route (
    .sts(sts_v), .en(en_v), .sci_mode(sci_mode),
    .sci(sci_irq), .smi(smi_irq), .wake(wake)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_STS: reg_rdata <= sts_word;
        ADDR_EN:  reg_rdata <= en_word;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk
  import pm_evt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rtc_rst_n,
  input logic        sci_mode,
  input logic        fw_release,
  input logic        pwrbtn_event,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic        wd_gbl,
  input logic [15:0] reg_rdata,
  input logic        sts_gbl,
  input logic        sts_pwr,
  input logic        en_any,
  input logic        en_rtc,
  input logic        sci_irq,
  input logic        smi_irq,
  input logic        wake
);
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~BIT_MASK) == 16'h0); // R11

  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_event |=> sts_pwr); // R4

  AST_W1C_GBL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_STS && wd_gbl && !fw_release) |=> !sts_gbl); // R3

  AST_PWR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_pwr |-> wake); // R8

  AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_any |-> (!sci_irq && !smi_irq)); // R5

  AST_MODE_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    sci_mode |-> !smi_irq); // R5

  AST_RTC_EN_KEEP: assert property (@(posedge clk) disable iff (!rtc_rst_n)
    (!rst_n && !reg_wr) |=> $stable(en_rtc)); // R10
endmodule

bind pm_event_ctrl pm_event_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .sci_mode(sci_mode),
  .fw_release(fw_release), .pwrbtn_event(pwrbtn_event), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wd_gbl(reg_wdata[5]), .reg_rdata(reg_rdata),
  .sts_gbl(sts_v[pm_evt_pkg::SRC_GBL]), .sts_pwr(sts_v[pm_evt_pkg::SRC_PWR]),
  .en_any(|en_v), .en_rtc(en_v[pm_evt_pkg::SRC_RTC]),
  .sci_irq(sci_irq), .smi_irq(smi_irq), .wake(wake)
);

// File: tb/pm_event_ctrl_test.sv
`timescale 1ns/1ps
module pm_event_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, rtc_rst_n, sci_mode, fw_release, rtc_event, pwrbtn_event;
  logic [1:0] reg_addr;
  logic reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic sci_irq, smi_irq, wake;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pm_event_ctrl #(.TMR_W(6), .TMR_TAP(4)) uut (
    .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .sci_mode(sci_mode),
    .fw_release(fw_release), .rtc_event(rtc_event), .pwrbtn_event(pwrbtn_event),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sci_irq(sci_irq), .smi_irq(smi_irq), .wake(wake)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic outs(input string tag, input logic s, input logic m, input logic w);
    chk(tag, {13'h0, sci_irq, smi_irq, wake}, {13'h0, s, m, w});
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rst_n = 0; rtc_rst_n = 0; sci_mode = 0; fw_release = 0; rtc_event = 0;
    pwrbtn_event = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; rtc_rst_n = 1;
    rd(2'b00, d); chk("R1 status after reset", d, 16'h0000);
    rd(2'b10, d); chk("R1 enable after reset", d, 16'h0000);
    outs("R1 outputs after reset", 0, 0, 0);
  endtask

  task automatic t_timer;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (16) @(posedge clk);
    @(negedge clk); reg_rd = 1; reg_addr = 2'b00;
    @(posedge clk);
    @(negedge clk); chk("R2 timer not yet set", {15'h0, reg_rdata[0]}, 16'h0);
    @(posedge clk);
    @(negedge clk); chk("R2 first timer set", {15'h0, reg_rdata[0]}, 16'h1);
    reg_rd = 0; reg_wr = 1; reg_wdata = 16'h0001;
    @(posedge clk);
    @(negedge clk); reg_wr = 0;
    repeat (29) @(posedge clk);
    @(negedge clk); reg_rd = 1;
    @(posedge clk);
    @(negedge clk); chk("R2 R3 timer cleared, next not yet", {15'h0, reg_rdata[0]}, 16'h0);
    @(posedge clk);
    @(negedge clk); chk("R2 second timer set", {15'h0, reg_rdata[0]}, 16'h1);
    reg_rd = 0;
  endtask

  task automatic t_tmr_route;
    sci_mode = 0;
    wr(2'b10, 16'h0000);
    repeat (70) @(negedge clk);
    outs("R5 timer with enable off", 0, 0, 0);
    wr(2'b10, 16'h0001);
    outs("R5 timer to SMI", 0, 1, 0);
    sci_mode = 1; #1;
    outs("R5 timer to SCI", 1, 0, 0);
    wr(2'b00, 16'h0001);
    outs("R12 timer cleared drops SCI", 0, 0, 0);
    wr(2'b10, 16'h0000);
    sci_mode = 0;
  endtask

  task automatic t_global;
    logic [15:0] d;
    @(negedge clk); fw_release = 1;
    @(negedge clk); fw_release = 0;
    rd(2'b00, d); chk("R6 global status set", d & 16'hFFFE, 16'h0020);
    outs("R6 global without enable", 0, 0, 0);
    wr(2'b10, 16'h0020);
    outs("R6 global to SCI in SMI mode", 1, 0, 0);
    wr(2'b00, 16'h0000);
    rd(2'b00, d); chk("R3 write 0 keeps status", d & 16'hFFFE, 16'h0020);
    wr(2'b00, 16'h0020);
    rd(2'b00, d); chk("R3 write 1 clears status", d & 16'hFFFE, 16'h0000);
    outs("R12 SCI drops after clear", 0, 0, 0);
    wr(2'b10, 16'h0000);
  endtask

  task automatic t_pwrbtn;
    logic [15:0] d;
    @(negedge clk); pwrbtn_event = 1;
    @(negedge clk); pwrbtn_event = 0;
    rd(2'b00, d); chk("R7 button sets status with enable off", d & 16'hFFFE, 16'h0100);
    outs("R8 wake without enable", 0, 0, 1);
    wr(2'b10, 16'h0100);
    outs("R7 button to SMI", 0, 1, 1);
    sci_mode = 1; #1;
    outs("R7 button to SCI", 1, 0, 1);
    wr(2'b00, 16'h0100);
    outs("R12 button cleared", 0, 0, 0);
    sci_mode = 0;
    wr(2'b10, 16'h0000);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    @(negedge clk);
    pwrbtn_event = 1; reg_wr = 1; reg_addr = 2'b00; reg_wdata = 16'h0100;
    @(posedge clk);
    @(negedge clk); pwrbtn_event = 0; reg_wr = 0;
    rd(2'b00, d); chk("R4 set wins over clear", d & 16'hFFFE, 16'h0100);
    wr(2'b00, 16'h0100);
    rd(2'b00, d); chk("R4 later clear works", d & 16'hFFFE, 16'h0000);
  endtask

  task automatic t_rtc;
    logic [15:0] d;
    @(negedge clk); rtc_event = 1;
    @(negedge clk); rtc_event = 0;
    rd(2'b00, d); chk("R9 rtc status set", d & 16'hFFFE, 16'h0400);
    outs("R9 rtc without enable", 0, 0, 0);
    wr(2'b10, 16'h0400);
    outs("R9 rtc to SMI and wake", 0, 1, 1);
    sci_mode = 1; #1;
    outs("R9 rtc to SCI and wake", 1, 0, 1);
    sci_mode = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(2'b10, d); chk("R10 rtc enable kept over main reset", d, 16'h0400);
    rd(2'b00, d); chk("R10 status cleared by main reset", d & 16'hFFFE, 16'h0000);
    @(negedge clk); rtc_rst_n = 0;
    @(negedge clk); rtc_rst_n = 1;
    rd(2'b10, d); chk("R10 rtc reset clears enable", d, 16'h0000);
  endtask

  task automatic t_reserved;
    logic [15:0] d;
    wr(2'b10, 16'hFFFF);
    rd(2'b10, d); chk("R11 enable reserved bits", d, 16'h0521);
    rd(2'b01, d); chk("R11 unused address reads 0", d, 16'h0000);
    wr(2'b11, 16'hFFFF);
    rd(2'b11, d); chk("R11 unused address ignores write", d, 16'h0000);
    rd(2'b00, d); chk("R11 status reserved bits", d & 16'hFAFE, 16'h0000);
    wr(2'b10, 16'h0000);
    rd(2'b10, d); chk("R11 enable cleared", d, 16'h0000);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timer();
    t_tmr_route();
    t_global();
    t_pwrbtn();
    t_collide();
    t_rtc();
    t_reserved();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule